// File: doc/BRIEF.md
# Load/Store Lane Unit

This unit sits between a processor datapath and a byte-addressable data memory organised as wide words. For every access it receives a request strobe, a write flag, an address already computed by the ALU, a three-bit width code and the register value to store. It forwards a word-aligned address to memory. It decides which byte lanes a store touches, and it places the store data on those lanes. It also checks that the address suits the access width.

Loads complete one cycle after they are issued. The memory returns its whole word in that following cycle. The unit keeps the lane offset and the width of the pending load, then picks the addressed byte, halfword or word out of the returned word and extends it to 32 bits with sign or zero fill. A misaligned or illegal access raises a flag. It then issues no memory request, writes nothing, and a load returns zero.

Top module: `ldst_lane_unit`

## Requirements
- R1: A word access (width code 010) with address bits [1:0] not equal to 00 raises `misalign_o` in the same cycle as the request.
- R2: A halfword access (codes 001, 101) with address bit 0 set raises `misalign_o`. A byte access (codes 000, 100) never raises it, at any address.
- R3: While `misalign_o` is high, `mem_req_o`, `mem_we_o` and every bit of `mem_be_o` stay low. A misaligned load still returns a response, and its data is zero.
- R4: An aligned store drives `mem_be_o` as follows. A byte store gives 0001 shifted left by address bits [1:0]. A halfword store gives 0011 shifted left by twice address bit 1. A word store gives 1111. Loads and idle cycles drive all byte enables to zero.
- R5: Store data appears on every lane. The low byte of `st_data_i` is repeated four times for a byte store. The low halfword is repeated twice for a halfword store. A word store passes the word through unchanged.
- R6: An issued load (request high, write flag low) gives `ld_valid_o` high exactly one cycle later. The returned data is taken from `mem_rdata_i` in that later cycle.
- R7: The load width codes work as follows. 000 sign-extends a byte. 001 sign-extends a halfword. 010 returns a full word. 100 zero-extends a byte. 101 zero-extends a halfword. The lane is chosen by the low address bits of the issuing cycle.
- R8: Width codes 011, 110 and 111 are illegal, and they raise `misalign_o` at any address.
- R9: A store never produces a load response. Whenever `ld_valid_o` is low, `ld_data_o` is zero.
- R10: Reset clears any pending load response at once and leaves all memory strobes low.
- R11: `mem_addr_o` equals the request address with its lane-offset bits cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request from the datapath |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte address from the ALU |
| width_i | input | 3 | Width and extension code (funct3) |
| st_data_i | input | 32 | Register value to store |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Lane-aligned memory address |
| mem_be_o | output | BUS_W/8 | Byte-lane write enables |
| mem_wdata_o | output | BUS_W | Lane-placed store data |
| mem_rdata_i | input | BUS_W | Word returned by memory one cycle after a read |
| misalign_o | output | 1 | Misaligned or illegal access flag |
| ld_valid_o | output | 1 | Load response valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
The bench builds the unit with its default parameters: a 32-bit memory bus, a 32-bit address and lane replication for store data. With these settings all four byte lanes, both halfword halves and every legal and illegal width code can be reached through a behavioural memory of sixteen words. Stores fill the memory first, and loads then read it back. A misaligned store at the same word is followed by a load that shows the word unchanged. This confirms that the suppressed write really left no trace. The shift-only store variant and the 64-bit bus are not built by this bench.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   // Access width codes, as carried in funct3
   typedef enum logic [2:0] {
      ACC_BYTE   = 3'b000,
      ACC_HALF   = 3'b001,
      ACC_WORD   = 3'b010,
      ACC_BYTE_U = 3'b100,
      ACC_HALF_U = 3'b101
   } acc_width_e;

   typedef struct packed {
      logic [1:0] size_lg;  // log2 of the access size in bytes
      logic       zext;     // zero-extend on load
      logic       legal;    // code is one of the five defined ones
   } acc_kind_t;

   function automatic acc_kind_t classify(input logic [2:0] code);
      acc_kind_t k;
      k.size_lg = code[1:0];
      k.zext    = code[2];
      case (code)
         ACC_BYTE, ACC_HALF, ACC_WORD, ACC_BYTE_U, ACC_HALF_U: k.legal = 1'b1;
         default:                                               k.legal = 1'b0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ldst_width_decode.sv
module ldst_width_decode
   import ldst_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [2:0]       width_i,
   input  logic [OFF_W-1:0] addr_lo_i,
   output logic [1:0]       size_lg_o,
   output logic             zext_o,
   output logic             misalign_o
);

   acc_kind_t        kind;
   logic [OFF_W-1:0] must_be_zero;

   always_comb begin
      kind = classify(width_i);
      case (kind.size_lg)
         2'd0:    must_be_zero = '0;
         2'd1:    must_be_zero = OFF_W'(1);
         default: must_be_zero = OFF_W'(3);
      endcase
   end

   assign size_lg_o  = kind.size_lg;
   assign zext_o     = kind.zext;
   assign misalign_o = req_i & (~kind.legal | (|(addr_lo_i & must_be_zero)));

   // R2
   byte_any_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (width_i == 3'b000 || width_i == 3'b100)) |-> !misalign_o);

   // R8
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (width_i == 3'b011 || width_i[2:1] == 2'b11)) |-> misalign_o);

   // R1
   idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |-> !misalign_o);

endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes #(
   parameter int BUS_W     = 32,
   parameter int XLEN      = 32,
   parameter bit REPLICATE = 1'b1,
   localparam int LANES    = BUS_W / 8,
   localparam int OFF_W    = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [1:0]       size_lg_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [XLEN-1:0]  data_i,
   output logic [LANES-1:0] be_o,
   output logic [BUS_W-1:0] wdata_o
);

   logic [LANES-1:0] base_mask;

   always_comb begin
      case (size_lg_i)
         2'd0:    base_mask = LANES'(1);
         2'd1:    base_mask = LANES'(3);
         default: base_mask = LANES'(15);
      endcase
   end

   assign be_o = en_i ? (base_mask << off_i) : '0;

   generate
      if (REPLICATE) begin : g_replicate
         always_comb begin
            case (size_lg_i)
               2'd0:    wdata_o = {(BUS_W/8){data_i[7:0]}};
               2'd1:    wdata_o = {(BUS_W/16){data_i[15:0]}};
               default: wdata_o = {(BUS_W/32){data_i[31:0]}};
            endcase
         end
      end else begin : g_shift
         logic [BUS_W-1:0] chunk;
         always_comb begin
            case (size_lg_i)
               2'd0:    chunk = BUS_W'(data_i[7:0]);
               2'd1:    chunk = BUS_W'(data_i[15:0]);
               default: chunk = BUS_W'(data_i[31:0]);
            endcase
         end
         assign wdata_o = chunk << {off_i, 3'b000};
      end
   endgenerate

   // R4
   be_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> (be_o == '0));

   // R4
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && size_lg_i == 2'd0) |-> ($countones(be_o) == 1));

   // R4
   half_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && size_lg_i == 2'd1) |-> ($countones(be_o) == 2));

endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align #(
   parameter int BUS_W  = 32,
   parameter int XLEN   = 32,
   localparam int OFF_W = $clog2(BUS_W / 8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             bad_i,
   input  logic [1:0]       size_lg_i,
   input  logic             zext_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [BUS_W-1:0] rdata_i,
   output logic             valid_o,
   output logic [XLEN-1:0]  data_o
);

   logic             vld_q, bad_q, zext_q;
   logic [1:0]       size_q;
   logic [OFF_W-1:0] off_q;
   logic [BUS_W-1:0] shifted;
   logic [XLEN-1:0]  extended;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         bad_q  <= 1'b0;
         zext_q <= 1'b0;
         size_q <= 2'd0;
         off_q  <= '0;
      end else begin
         vld_q  <= take_i;
         bad_q  <= bad_i;
         zext_q <= zext_i;
         size_q <= size_lg_i;
         off_q  <= off_i;
      end
   end

   assign shifted = rdata_i >> {off_q, 3'b000};

   always_comb begin
      case (size_q)
         2'd0:    extended = {{(XLEN-8){~zext_q & shifted[7]}}, shifted[7:0]};
         2'd1:    extended = {{(XLEN-16){~zext_q & shifted[15]}}, shifted[15:0]};
         default: extended = shifted[XLEN-1:0];
      endcase
   end

   assign valid_o = vld_q;
   assign data_o  = (vld_q && !bad_q) ? extended : '0;

   // R9
   idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (data_o == '0));

   // R6
   resp_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(take_i));

   // R3
   bad_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(bad_i)) |-> (data_o == '0));

endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit #(
   parameter int ADDR_W          = 32,
   parameter int BUS_W           = 32,
   parameter bit REPLICATE_STORE = 1'b1,
   localparam int XLEN           = 32,
   localparam int LANES          = BUS_W / 8,
   localparam int OFF_W          = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [2:0]        width_i,
   input  logic [XLEN-1:0]   st_data_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic [BUS_W-1:0]  mem_wdata_o,
   input  logic [BUS_W-1:0]  mem_rdata_i,
   output logic              misalign_o,
   output logic              ld_valid_o,
   output logic [XLEN-1:0]   ld_data_o
);

   generate
      if (BUS_W != 32 && BUS_W != 64) begin : g_bad_bus
         $error("ldst_lane_unit: BUS_W must be 32 or 64");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ldst_lane_unit: ADDR_W too narrow for the lane offset");
      end
   endgenerate

   logic [1:0]       size_lg;
   logic             zext;
   logic             access_ok;
   logic [OFF_W-1:0] lane_off;

   assign lane_off = addr_i[OFF_W-1:0];

   ldst_width_decode #(.OFF_W(OFF_W)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .width_i    (width_i),
      .addr_lo_i  (lane_off),
      .size_lg_o  (size_lg),
      .zext_o     (zext),
      .misalign_o (misalign_o)
   );

   assign access_ok  = req_i & ~misalign_o;
   assign mem_req_o  = access_ok;
   assign mem_we_o   = access_ok & we_i;
   assign mem_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   ldst_store_lanes #(
      .BUS_W     (BUS_W),
      .XLEN      (XLEN),
      .REPLICATE (REPLICATE_STORE)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (access_ok & we_i),
      .size_lg_i (size_lg),
      .off_i     (lane_off),
      .data_i    (st_data_i),
      .be_o      (mem_be_o),
      .wdata_o   (mem_wdata_o)
   );

   ldst_load_align #(
      .BUS_W (BUS_W),
      .XLEN  (XLEN)
   ) u_load (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (req_i & ~we_i),
      .bad_i     (misalign_o),
      .size_lg_i (size_lg),
      .zext_i    (zext),
      .off_i     (lane_off),
      .rdata_i   (mem_rdata_i),
      .valid_o   (ld_valid_o),
      .data_o    (ld_data_o)
   );

   // R3
   misalign_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0));

   // R9
   store_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && we_i) |=> !ld_valid_o);

   // R4
   load_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i) |-> (mem_be_o == '0));

endmodule

// File: tb/tb_ldst_lane_unit.sv
`timescale 1ns/1ps
module tb_ldst_lane_unit;

   localparam real CLK_P = 4.0;
   localparam int  NV    = 29;

   typedef struct packed {
      logic        we;
      logic [2:0]  w;
      logic [31:0] addr;
      logic [31:0] sdata;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        mis;
      logic [31:0] ld;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'b010, 32'h00, 32'h8765_43A1, 4'hF, 32'h8765_43A1, 1'b0, 32'h0},
      '{1'b1, 3'b000, 32'h05, 32'h1234_56F0, 4'h2, 32'hF0F0_F0F0, 1'b0, 32'h0},
      '{1'b1, 3'b001, 32'h06, 32'hABCD_8001, 4'hC, 32'h8001_8001, 1'b0, 32'h0},
      '{1'b1, 3'b010, 32'h0A, 32'hFFFF_FFFF, 4'h0, 32'h0,         1'b1, 32'h0},
      '{1'b1, 3'b001, 32'h03, 32'hFFFF_FFFF, 4'h0, 32'h0,         1'b1, 32'h0},
      '{1'b1, 3'b000, 32'h08, 32'h0000_007F, 4'h1, 32'h7F7F_7F7F, 1'b0, 32'h0},
      '{1'b0, 3'b010, 32'h00, 32'h0, 4'h0, 32'h0, 1'b0, 32'h8765_43A1},
      '{1'b0, 3'b000, 32'h00, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF_FFA1},
      '{1'b0, 3'b100, 32'h00, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_00A1},
      '{1'b0, 3'b000, 32'h01, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_0043},
      '{1'b0, 3'b001, 32'h02, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF_8765},
      '{1'b0, 3'b101, 32'h02, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_8765},
      '{1'b0, 3'b000, 32'h05, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF_FFF0},
      '{1'b0, 3'b100, 32'h05, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_00F0},
      '{1'b0, 3'b001, 32'h06, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF_8001},
      '{1'b0, 3'b010, 32'h04, 32'h0, 4'h0, 32'h0, 1'b0, 32'h8001_F000},
      '{1'b0, 3'b010, 32'h08, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_007F},
      '{1'b0, 3'b001, 32'h01, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0},
      '{1'b0, 3'b010, 32'h06, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0},
      '{1'b0, 3'b000, 32'h03, 32'h0, 4'h0, 32'h0, 1'b0, 32'hFFFF_FF87},
      '{1'b0, 3'b101, 32'h00, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_43A1},
      '{1'b0, 3'b011, 32'h00, 32'h0, 4'h0, 32'h0, 1'b1, 32'h0},
      '{1'b0, 3'b010, 32'h0C, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0},
      '{1'b1, 3'b000, 32'h0F, 32'h0000_0055, 4'h8, 32'h5555_5555, 1'b0, 32'h0},
      '{1'b0, 3'b100, 32'h0F, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_0055},
      '{1'b0, 3'b101, 32'h0E, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_5500},
      '{1'b0, 3'b000, 32'h0F, 32'h0, 4'h0, 32'h0, 1'b0, 32'h0000_0055},
      '{1'b1, 3'b110, 32'h00, 32'h1111_1111, 4'h0, 32'h0, 1'b1, 32'h0},
      '{1'b0, 3'b010, 32'h00, 32'h0, 4'h0, 32'h0, 1'b0, 32'h8765_43A1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [31:0] addr = '0;
   logic [2:0]  width = '0;
   logic [31:0] sdata = '0;
   logic        mem_req, mem_we, misalign, ld_valid;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_be;
   logic [31:0] rdata;
   logic [31:0] mem [16];

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ldst_lane_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .we_i        (we),
      .addr_i      (addr),
      .width_i     (width),
      .st_data_i   (sdata),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_addr_o  (mem_addr),
      .mem_be_o    (mem_be),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (rdata),
      .misalign_o  (misalign),
      .ld_valid_o  (ld_valid),
      .ld_data_o   (ld_data)
   );

   // behavioural memory: one-cycle read latency, per-lane writes
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) mem[k] <= '0;
         rdata <= '0;
      end else if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            rdata <= mem[mem_addr[5:2]];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   function automatic string mis_tag(input logic [2:0] w);
      if (w == 3'b011 || w[2:1] == 2'b11) return "R8 illegal code";
      if (w[1:0] == 2'b10) return "R1 word alignment";
      return "R2 half/byte alignment";
   endfunction

   initial begin
      #(CLK_P * 200000);
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 ld_valid in reset", 32'(ld_valid), 32'h0);
      chk("R10 mem_req in reset", 32'(mem_req), 32'h0);
      chk("R10 be in reset", 32'(mem_be), 32'h0);
      rst_n = 1'b1;

      // R4 idle cycle with store-like inputs but no request
      @(negedge clk);
      we = 1'b1; width = 3'b010; addr = 32'h4; sdata = 32'hDEAD_BEEF;
      #1;
      chk("R4 idle be", 32'(mem_be), 32'h0);
      chk("R4 idle mem_we", 32'(mem_we), 32'h0);
      chk("R1 idle misalign", 32'(misalign), 32'h0);

      // vector walk
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (VEC[i-1].we) begin
               chk("R9 store gives no response", 32'(ld_valid), 32'h0);
               chk("R9 data zero when idle", ld_data, 32'h0);
            end else begin
               chk("R6 load response valid", 32'(ld_valid), 32'h1);
               chk(VEC[i-1].mis ? "R3 misaligned load data" : "R7 load data",
                   ld_data, VEC[i-1].ld);
            end
         end
         if (i < NV) begin
            req = 1'b1; we = VEC[i].we; width = VEC[i].w;
            addr = VEC[i].addr; sdata = VEC[i].sdata;
            #1;
            chk(mis_tag(VEC[i].w), 32'(misalign), 32'(VEC[i].mis));
            chk("R4 byte enables", 32'(mem_be), 32'(VEC[i].be));
            chk("R11 aligned address", mem_addr, VEC[i].addr & ~32'h3);
            if (VEC[i].mis) begin
               chk("R3 request blocked", 32'({mem_req, mem_we}), 32'h0);
            end else if (VEC[i].we) begin
               chk("R5 store data lanes", mem_wdata, VEC[i].wdata);
               chk("R4 write strobe", 32'(mem_we), 32'h1);
            end
         end
      end

      // R6 response latency: not in issuing cycle, present next, gone after
      req = 1'b0;
      @(negedge clk);
      req = 1'b1; we = 1'b0; width = 3'b010; addr = 32'h4;
      #1;
      chk("R6 no same-cycle response", 32'(ld_valid), 32'h0);
      @(negedge clk);
      req = 1'b0;
      chk("R6 next-cycle response", ld_data, 32'h8001_F000);
      @(negedge clk);
      chk("R9 response ends", 32'(ld_valid), 32'h0);

      // R10 reset kills a pending response
      req = 1'b1; we = 1'b0; width = 3'b000; addr = 32'h1;
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      chk("R10 pending response cleared", 32'(ld_valid), 32'h0);
      chk("R10 data cleared", ld_data, 32'h0);
      req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      @(negedge clk);
      finish_run();
   end

endmodule